// File: doc/BRIEF.md
# PHY Interrupt Controller with Shared Interrupt / Power-Down Pin

This block is the interrupt logic of an Ethernet PHY management interface. Single-cycle pulses from six status-change detectors are each latched into a sticky flag: link change, speed change, duplex change, auto-negotiation done, energy-detect change, and a statistics counter reaching half-full. Each flag is gated by its own enable bit, and a global enable gates them all. A pending enabled flag raises an active-low interrupt. All flags clear together when software reads the event register. A test bit forces the interrupt for as long as it stays set, whatever the event state.

Software reaches the registers over a simple synchronous port. It presents an address, a write enable with 16-bit data, and a read strobe. Read data comes back one cycle after the strobe.

A single pad is shared between two uses, and a control bit picks one:
- **Interrupt output.** The block drives the pad with the interrupt.
- **Power-down input.** The block releases the pad. The pad level passes through a synchronizer, and a low level is presented as a power-down request.

All pins are plain control and status pins. There is no streaming data path, so no valid/ready handshake and no back-pressure.

Top module: `phy_irq_ctrl`

## Requirements
- R1: After reset, both registers read 0, no flag is pending, `pad_oe` is 0 and `pad_o` is 1.
- R2: The control register is at address 0x11. Its fields are:
  - bit 0: test
  - bit 1: global enable
  - bit 2: pad drive

  All three bits are read/write. Bits 15:3 ignore writes and read 0.
- R3: Read data appears on `reg_rdata` in the cycle after `reg_rd` is sampled high. With no strobe, `reg_rdata` is 0. An unmapped address reads 0.
- R4: A pulse on `evt_pulse[i]` sets status flag i at the next clock edge. The flag stays set until the event register is read.
- R5: A read of the event register clears all flags at the strobe edge and returns their old values. An event pulsing in the same cycle as that read stays latched.
- R6: The event register is at address 0x12. Its fields are:
  - bits 5:0: per-event enables, read/write
  - bits 13:8: status flags, read-only; writes to them are ignored
  - all other bits read 0

  Event index order is link, speed, duplex, auto-negotiation done, energy detect, counter half-full.
- R7: `pad_o` is low exactly when the test bit is 1, or when the global enable is 1 and some flag with its enable set is pending. Otherwise `pad_o` is high.
- R8: While the test bit is 1, `pad_o` is low regardless of flags, enables and global enable.
- R9: `pad_oe` equals the pad-drive bit. When that bit is 0, the pad is not driven.
- R10: While pad drive is 0, `pd_req` is the inverse of `pad_i` delayed by two clock edges. While pad drive is 1, `pd_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 5 | Register address |
| reg_wr | input | 1 | Write enable |
| reg_wdata | input | 16 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 16 | Read data, one cycle after the strobe |
| evt_pulse | input | 6 | Event pulses, one bit per source |
| pad_o | output | 1 | Active-low interrupt level to the pad |
| pad_oe | output | 1 | Pad output enable |
| pad_i | input | 1 | Pad level seen by the input buffer |
| pd_req | output | 1 | Synchronized power-down request |

## Verification
The main function is swept over every combination of the six enables, the global enable and the six-bit event pattern. For each combination the bench checks the interrupt level, the register readback and the clear after the read. This separates correct per-bit AND-gating from any masking that confuses bits or ignores the global enable.

Several directed patterns cover the remaining behaviour:
- An event arriving on the same cycle as a read, which tells apart a clear that loses the new event from one that keeps it.
- The test bit set with all other sources off.
- A pad level walked low and high under both pad modes, which checks the two-edge latency and the forced-off request.
- Writes to reserved and read-only bits, and reads of unmapped addresses.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;
  localparam int unsigned REG_AW   = 5;
  localparam int unsigned REG_DW   = 16;
  localparam int unsigned FLAG_LSB = 8;
  localparam logic [REG_AW-1:0] ADDR_CTRL = 5'h11;
  localparam logic [REG_AW-1:0] ADDR_EVT  = 5'h12;

  typedef struct packed {
    logic pad_drive;
    logic glob_en;
    logic test;
  } ctrl_t;
endpackage

// File: rtl/phy_irq_ctrl_reg.sv
module phy_irq_ctrl_reg
  import phy_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_hit,
  input  logic [2:0]  wdata,
  output ctrl_t       ctrl
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl <= '0;
    else if (wr_hit) ctrl <= ctrl_t'(wdata);
  end

  assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(ctrl));
endmodule

// File: rtl/phy_irq_evt_bank.sv
module phy_irq_evt_bank #(
  parameter int unsigned NUM_EVT = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_wr,
  input  logic [NUM_EVT-1:0] en_wdata,
  input  logic               rd_clr,
  input  logic [NUM_EVT-1:0] evt,
  output logic [NUM_EVT-1:0] flags,
  output logic [NUM_EVT-1:0] en,
  output logic               pending
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en <= '0;
    else if (en_wr) en <= en_wdata;
  end

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flags[i] <= 1'b0;
      else if (evt[i]) flags[i] <= 1'b1;
      else if (rd_clr) flags[i] <= 1'b0;
    end

    assert_evt_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> flags[i]);
    assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[i] && !rd_clr) |=> flags[i]);
  end

  assign pending = |(flags & en);

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && evt == '0) |=> (flags == '0));
endmodule

// File: rtl/phy_irq_sync.sv
module phy_irq_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];

  if (STAGES == 2) begin : g_chk
    assert_sync_delay_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n, 2) |-> (dout == $past(din, 2)));
  end
endmodule

// File: rtl/phy_irq_ctrl.sv
module phy_irq_ctrl
  import phy_irq_pkg::*;
#(
  parameter int unsigned NUM_EVT     = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic [REG_DW-1:0]  reg_wdata,
  input  logic               reg_rd,
  output logic [REG_DW-1:0]  reg_rdata,
  input  logic [NUM_EVT-1:0] evt_pulse,
  output logic               pad_o,
  output logic               pad_oe,
  input  logic               pad_i,
  output logic               pd_req
);
  ctrl_t              ctrl;
  logic [NUM_EVT-1:0] flags, en;
  logic               pending, pad_sync;
  logic               hit_ctrl, hit_evt;
  logic [REG_DW-1:0]  rd_word;

  assign hit_ctrl = (reg_addr == ADDR_CTRL);
  assign hit_evt  = (reg_addr == ADDR_EVT);

  phy_irq_ctrl_reg u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_hit (reg_wr && hit_ctrl),
    .wdata  (reg_wdata[2:0]),
    .ctrl   (ctrl)
  );

  phy_irq_evt_bank #(.NUM_EVT(NUM_EVT)) u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_wr    (reg_wr && hit_evt),
    .en_wdata (reg_wdata[NUM_EVT-1:0]),
    .rd_clr   (reg_rd && hit_evt),
    .evt      (evt_pulse),
    .flags    (flags),
    .en       (en),
    .pending  (pending)
  );

  phy_irq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (pad_i),
    .dout  (pad_sync)
  );

  // Readback mux: event word packs enables low, flags from FLAG_LSB up.
  always_comb begin
    rd_word = '0;
    if (hit_ctrl) begin
      rd_word[2:0] = ctrl;
    end else if (hit_evt) begin
      rd_word[NUM_EVT-1:0]           = en;
      rd_word[FLAG_LSB +: NUM_EVT]   = flags;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_word;
    else             reg_rdata <= '0;
  end

  // Active-low interrupt and pad direction.
  assign pad_o  = !(ctrl.test || (ctrl.glob_en && pending));
  assign pad_oe = ctrl.pad_drive;
  assign pd_req = !ctrl.pad_drive && !pad_sync;

  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && hit_ctrl) |=> (reg_rdata[REG_DW-1:3] == '0));
  assert_unmapped_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !hit_ctrl && !hit_evt) |=> (reg_rdata == '0));
  assert_idle_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> (reg_rdata == '0));
  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.test && !ctrl.glob_en) |-> pad_o);
  assert_test_forces_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.test |-> !pad_o);
  assert_drive_blocks_pd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pad_oe |-> !pd_req);
endmodule

// File: tb/sim_phy_irq_ctrl.sv
module sim_phy_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic [15:0] reg_rdata;
  logic [5:0]  evt_pulse = '0;
  logic        pad_o, pad_oe, pd_req;
  logic        ext_level = 1'b1;
  logic        pad_i;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  // Pad model: the driver wins when enabled, otherwise the external level.
  assign pad_i = pad_oe ? pad_o : ext_level;

  phy_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .evt_pulse(evt_pulse), .pad_o(pad_o), .pad_oe(pad_oe),
    .pad_i(pad_i), .pd_req(pd_req)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [5:0] p);
    evt_pulse = p;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(pad_oe == 1'b0, "R1 pad_oe", pad_oe, 0);
    chk(pad_o == 1'b1, "R1 pad_o", pad_o, 1);
    rd(5'h11, d); chk(d == 16'h0, "R1 ctrl reset", d, 0);
    rd(5'h12, d); chk(d == 16'h0, "R1 evt reset", d, 0);

    // R3 idle and unmapped reads
    chk(reg_rdata == 16'h0, "R3 idle rdata", reg_rdata, 0);
    wr(5'h11, 16'h0002);
    rd(5'h10, d); chk(d == 16'h0, "R3 unmapped 0x10", d, 0);
    rd(5'h13, d); chk(d == 16'h0, "R3 unmapped 0x13", d, 0);
    @(negedge clk);
    chk(reg_rdata == 16'h0, "R3 rdata after strobe", reg_rdata, 0);

    // R2 reserved bits ignored
    wr(5'h11, 16'hFFF8);
    rd(5'h11, d); chk(d == 16'h0, "R2 reserved write", d, 0);
    wr(5'h11, 16'hFFFD);
    rd(5'h11, d); chk(d == 16'h0005, "R2 rw bits", d, 5);

    // R8 test bit forces interrupt with everything else off
    chk(pad_o == 1'b0, "R8 test forces", pad_o, 0);
    chk(pad_oe == 1'b1, "R9 pad_oe on", pad_oe, 1);
    wr(5'h11, 16'h0004);
    chk(pad_o == 1'b1, "R8 test cleared", pad_o, 1);

    // R6 flag bits read-only
    wr(5'h12, 16'h3F3F);
    rd(5'h12, d); chk(d == 16'h003F, "R6 flags read-only", d, 16'h3F);

    // R4 R5 R6 R7 exhaustive sweep: global enable x enables x events
    for (int g = 0; g < 2; g++) begin
      wr(5'h11, 16'(4 + 2 * g));
      for (int e = 0; e < 64; e++) begin
        wr(5'h12, 16'(e));
        for (int p = 0; p < 64; p++) begin
          bit exp_irq;
          pulse(6'(p));
          exp_irq = (g == 1) && ((p & e) != 0);
          chk(pad_o == !exp_irq, "R7 gated irq", pad_o, int'(!exp_irq));
          rd(5'h12, d);
          chk(d == 16'((p << 8) | e), "R4 R6 readback", d, (p << 8) | e);
          chk(pad_o == 1'b1, "R5 cleared after read", pad_o, 1);
        end
      end
    end

    // R5 event in the same cycle as a read survives
    wr(5'h12, 16'h003F);
    pulse(6'h01);
    reg_addr = 5'h12; reg_rd = 1'b1; evt_pulse = 6'h20;
    @(negedge clk);
    reg_rd = 1'b0; evt_pulse = '0;
    chk(reg_rdata == 16'h013F, "R5 old value returned", reg_rdata, 16'h013F);
    rd(5'h12, d); chk(d == 16'h203F, "R5 same-cycle event kept", d, 16'h203F);

    // R9 R10 pad released, power-down request through synchronizer
    wr(5'h11, 16'h0000);
    chk(pad_oe == 1'b0, "R9 pad released", pad_oe, 0);
    ext_level = 1'b0;
    @(negedge clk);
    chk(pd_req == 1'b0, "R10 one edge not yet", pd_req, 0);
    @(negedge clk);
    chk(pd_req == 1'b1, "R10 two edges asserted", pd_req, 1);
    ext_level = 1'b1;
    @(negedge clk);
    chk(pd_req == 1'b1, "R10 release one edge", pd_req, 1);
    @(negedge clk);
    chk(pd_req == 1'b0, "R10 release two edges", pd_req, 0);
    ext_level = 1'b0;
    repeat (2) @(negedge clk);
    wr(5'h11, 16'h0004);
    chk(pd_req == 1'b0, "R10 forced off when driving", pd_req, 0);
    repeat (3) @(negedge clk);
    chk(pd_req == 1'b0, "R10 stays off when driving", pd_req, 0);

    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule